// File: doc/BRIEF.md
# Transient-Mode Supervisor for a Buck Regulator with Load-Side Auxiliary Current Unit

This block sits between the steady-state compensator of a buck regulator and its power switches. It watches two comparator bits: one that rises when the output voltage is above an upper threshold, and one that rises when it is below a lower threshold. While both bits are quiet, the compensator's switch commands pass straight through and the auxiliary current unit stays idle. When one comparator trips, the block takes over. It holds one power switch on continuously, so the inductor current slews as fast as possible. It also enables the auxiliary pulse unit to absorb or supply the current mismatch.

The supervisor has no current sensor, so it cannot tell directly when the inductor current has caught up with the load. It decides this from the comparator history alone. When the voltage falls back inside the window, it pauses the auxiliary unit but keeps the power switch forced. If the voltage leaves the window again on the same side, the auxiliary unit is re-armed. The transient ends in either of two ways: the comparators show the opposite side of the window, or a programmable halt timer expires with the voltage still inside the window. The block then spends one cycle forcing the switching action that is the opposite of the transient action, and hands control back to the compensator.

Top module: `tm_supervisor`

## Requirements
- R1: After reset, the block is in steady state. `aux_en_o`, `enter_o` and `exit_o` are low, and `hs_on_o`/`ls_on_o` follow `ss_hs_i`/`ss_ls_i`.
- R2: In steady state, with comparator pattern {over,under} = 00, the switch outputs follow the compensator inputs and the auxiliary unit stays disabled.
- R3: In steady state, pattern 10 (over only) starts an unloading transient. From then on `ls_on_o`=1, `hs_on_o`=0, `aux_en_o`=1 and `aux_sink_o`=1, and `enter_o` is high for exactly the first transient cycle.
- R4: In steady state, pattern 01 (under only) starts a loading transient. From then on `hs_on_o`=1, `ls_on_o`=0, `aux_en_o`=1 and `aux_sink_o`=0.
- R5: During a transient, pattern 00 drops `aux_en_o` at once. The transient switch drive and the `aux_sink_o` direction are kept.
- R6: While the auxiliary unit is paused, a return of the pattern that started the transient re-enables `aux_en_o` and clears the halt count. A later pause then lasts the full halt time again.
- R7: During a transient, the pattern opposite to the one that started it (01 after unloading, 10 after loading) ends the transient, whether the auxiliary unit is running or paused.
- R8: If the auxiliary unit stays paused with pattern 00 and `halt_preset_i` = P, the hand-off cycle follows exactly P+1 cycles after the first paused cycle.
- R9: The transient ends with a single hand-off cycle in which `exit_o`=1 and `aux_en_o`=0. In that cycle `hs_on_o`=1, `ls_on_o`=0 after unloading, and `hs_on_o`=0, `ls_on_o`=1 after loading. In the next cycle the switch outputs follow the compensator again.
- R10: A comparator change driven between rising edges shows at the outputs only after the third rising edge: two synchronizer stages plus the state register.
- R11: Pattern 11 is invalid and is ignored. In steady state it starts no transient. During a transient it holds the current state, and while paused it freezes the halt count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_over_i | input | 1 | Asynchronous comparator bit: output above upper threshold |
| cmp_under_i | input | 1 | Asynchronous comparator bit: output below lower threshold |
| halt_preset_i | input | TIMER_W | Halt time in clock cycles (P, the pause lasts P+1 cycles) |
| ss_hs_i | input | 1 | High-side command from the steady-state compensator |
| ss_ls_i | input | 1 | Low-side command from the steady-state compensator |
| hs_on_o | output | 1 | High-side switch drive |
| ls_on_o | output | 1 | Low-side switch drive |
| aux_en_o | output | 1 | Auxiliary pulse unit enable |
| aux_sink_o | output | 1 | Auxiliary direction: 1 sink (unloading), 0 source (loading) |
| enter_o | output | 1 | One-cycle pulse on entry into transient mode |
| exit_o | output | 1 | One-cycle pulse marking the hand-off cycle |

## Verification
A wrong stored direction shows in the first transient cycle: the forced switch and `aux_sink_o` disagree. It shows again in the hand-off cycle, because the forced action is no longer the inverse of the transient one. A halt count that is not cleared or not frozen changes the number of paused cycles before `exit_o`, so the tests measure that interval exactly against P+1 plus any frozen cycles. A mishandled invalid pattern shows within three cycles as a spurious `enter_o` or a change of `aux_en_o`.

// File: rtl/tm_pkg.sv
package tm_pkg;

  typedef enum logic [1:0] {
    ST_STEADY = 2'd0,
    ST_AUX    = 2'd1,
    ST_HALT   = 2'd2,
    ST_HAND   = 2'd3
  } tm_state_e;

  // comparator pattern {over, under}
  localparam logic [1:0] PAT_IDLE  = 2'b00;
  localparam logic [1:0] PAT_OVER  = 2'b10;
  localparam logic [1:0] PAT_UNDER = 2'b01;
  localparam logic [1:0] PAT_BOTH  = 2'b11;

endpackage

// File: rtl/tm_sync.sv
module tm_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/tm_halt_timer.sv
module tm_halt_timer #(
  parameter int unsigned TIMER_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               inc_i,
  input  logic [TIMER_W-1:0] preset_i,
  output logic               done_o
);

  logic [TIMER_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (inc_i && !done_o)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == preset_i);

endmodule

// File: rtl/tm_fsm.sv
module tm_fsm
  import tm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] pat_i,
  input  logic       timer_done_i,
  output tm_state_e  state_o,
  output logic       dir_unload_o,
  output logic       timer_clr_o,
  output logic       timer_inc_o,
  output logic       enter_o
);

  tm_state_e state_q, state_d;
  logic      dir_q, dir_d;
  logic      enter_q;
  logic      is_stored, is_inverse;

  assign is_stored  = dir_q ? (pat_i == PAT_OVER)  : (pat_i == PAT_UNDER);
  assign is_inverse = dir_q ? (pat_i == PAT_UNDER) : (pat_i == PAT_OVER);

  always_comb begin
    state_d = state_q;
    dir_d   = dir_q;
    unique case (state_q)
      ST_STEADY: begin
        if (pat_i == PAT_OVER) begin
          state_d = ST_AUX;
          dir_d   = 1'b1;
        end else if (pat_i == PAT_UNDER) begin
          state_d = ST_AUX;
          dir_d   = 1'b0;
        end
      end
      ST_AUX: begin
        if (is_inverse)              state_d = ST_HAND;
        else if (pat_i == PAT_IDLE)  state_d = ST_HALT;
      end
      ST_HALT: begin
        if (is_inverse)              state_d = ST_HAND;
        else if (is_stored)          state_d = ST_AUX;
        else if (pat_i == PAT_IDLE && timer_done_i) state_d = ST_HAND;
      end
      ST_HAND:   state_d = ST_STEADY;
      default:   state_d = ST_STEADY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_STEADY;
      dir_q   <= 1'b0;
      enter_q <= 1'b0;
    end else begin
      state_q <= state_d;
      dir_q   <= dir_d;
      enter_q <= (state_q == ST_STEADY) && (state_d == ST_AUX);
    end
  end

  // count only clean in-window cycles; invalid pattern freezes the count
  assign timer_clr_o  = (state_q != ST_HALT);
  assign timer_inc_o  = (state_q == ST_HALT) && (pat_i == PAT_IDLE);
  assign state_o      = state_q;
  assign dir_unload_o = dir_q;
  assign enter_o      = enter_q;

endmodule

// File: rtl/tm_supervisor.sv
module tm_supervisor
  import tm_pkg::*;
#(
  parameter int unsigned TIMER_W     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmp_over_i,
  input  logic               cmp_under_i,
  input  logic [TIMER_W-1:0] halt_preset_i,
  input  logic               ss_hs_i,
  input  logic               ss_ls_i,
  output logic               hs_on_o,
  output logic               ls_on_o,
  output logic               aux_en_o,
  output logic               aux_sink_o,
  output logic               enter_o,
  output logic               exit_o
);

  localparam int unsigned CMP_W = 2;

  logic [CMP_W-1:0] pat_s;
  tm_state_e        state;
  logic             dir_unload;
  logic             t_clr, t_inc, t_done;

  tm_sync #(.WIDTH(CMP_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cmp_over_i, cmp_under_i}),
    .q_o    (pat_s)
  );

  tm_halt_timer #(.TIMER_W(TIMER_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (t_clr),
    .inc_i    (t_inc),
    .preset_i (halt_preset_i),
    .done_o   (t_done)
  );

  tm_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pat_i        (pat_s),
    .timer_done_i (t_done),
    .state_o      (state),
    .dir_unload_o (dir_unload),
    .timer_clr_o  (t_clr),
    .timer_inc_o  (t_inc),
    .enter_o      (enter_o)
  );

  always_comb begin
    unique case (state)
      ST_AUX, ST_HALT: begin
        // unloading: low side on; loading: high side on
        hs_on_o = !dir_unload;
        ls_on_o =  dir_unload;
      end
      ST_HAND: begin
        // first action is the inverse of the transient action
        hs_on_o =  dir_unload;
        ls_on_o = !dir_unload;
      end
      default: begin
        hs_on_o = ss_hs_i;
        ls_on_o = ss_ls_i;
      end
    endcase
  end

  assign aux_en_o   = (state == ST_AUX);
  assign aux_sink_o = dir_unload;
  assign exit_o     = (state == ST_HAND);

endmodule

// File: rtl/tm_supervisor_chk.sv
module tm_supervisor_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic hs_on_o,
  input logic ls_on_o,
  input logic aux_en_o,
  input logic aux_sink_o,
  input logic enter_o,
  input logic exit_o
);

  // R3
  enter_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_o |=> !enter_o);

  // R3
  enter_aux_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_o |-> aux_en_o);

  // R3
  unload_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_en_o && aux_sink_o) |-> (ls_on_o && !hs_on_o));

  // R4
  load_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_en_o && !aux_sink_o) |-> (hs_on_o && !ls_on_o));

  // R9
  exit_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_o |=> (!exit_o && !aux_en_o));

  // R9
  handoff_action_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_o |-> (!aux_en_o && hs_on_o == aux_sink_o && ls_on_o == !aux_sink_o));

  // R5
  dir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_en_o && !enter_o) |-> $stable(aux_sink_o));

endmodule

bind tm_supervisor tm_supervisor_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hs_on_o    (hs_on_o),
  .ls_on_o    (ls_on_o),
  .aux_en_o   (aux_en_o),
  .aux_sink_o (aux_sink_o),
  .enter_o    (enter_o),
  .exit_o     (exit_o)
);

// File: tb/tb_tm_supervisor.sv
module tb_tm_supervisor;

  localparam int TW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cmp_over_i = 1'b0, cmp_under_i = 1'b0;
  logic [TW-1:0] halt_preset_i = '0;
  logic          ss_hs_i = 1'b0, ss_ls_i = 1'b1;
  logic          hs_on_o, ls_on_o, aux_en_o, aux_sink_o, enter_o, exit_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  tm_supervisor #(.TIMER_W(TW)) dut (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic drive(input logic ov, input logic un);
    cmp_over_i  = ov;
    cmp_under_i = un;
  endtask

  // cycles from first paused sample until exit_o
  task automatic count_to_exit(inout int cnt);
    for (int k = 0; k < 5000 && exit_o !== 1'b1; k++) begin
      step(1);
      cnt++;
    end
  endtask

  task automatic t_reset;
    chk("R1 aux_en", aux_en_o, 0);
    chk("R1 enter", enter_o, 0);
    chk("R1 exit", exit_o, 0);
    chk("R1 pass", {hs_on_o, ls_on_o}, {ss_hs_i, ss_ls_i});
  endtask

  task automatic t_steady_pass;
    drive(0, 0);
    ss_hs_i = 1; ss_ls_i = 0; step(1);
    chk("R2 pass hs", {hs_on_o, ls_on_o}, 2'b10);
    ss_hs_i = 0; ss_ls_i = 1; step(1);
    chk("R2 pass ls", {hs_on_o, ls_on_o}, 2'b01);
    chk("R2 aux idle", aux_en_o, 0);
  endtask

  task automatic t_invalid_steady;
    drive(1, 1);
    for (int k = 0; k < 6; k++) begin
      step(1);
      chk("R11 steady both", {aux_en_o, enter_o}, 2'b00);
    end
    drive(0, 0); step(4);
  endtask

  task automatic t_unload_invert;
    drive(1, 0); step(2);
    chk("R10 not yet", aux_en_o, 0);
    step(1);
    chk("R3 unload drive", {hs_on_o, ls_on_o, aux_en_o, aux_sink_o, enter_o}, 5'b01111);
    step(1);
    chk("R3 enter single", enter_o, 0);
    drive(0, 1); step(1);
    drive(0, 0); step(2);
    chk("R7 inverse exit", exit_o, 1);
    chk("R9 unload handoff", {hs_on_o, ls_on_o, aux_en_o}, 3'b100);
    step(1);
    chk("R9 back to pass", {exit_o, hs_on_o, ls_on_o}, {1'b0, ss_hs_i, ss_ls_i});
    step(3);
  endtask

  task automatic t_load_timer;
    int cnt = 0;
    halt_preset_i = 5;
    drive(0, 1); step(3);
    chk("R4 load drive", {hs_on_o, ls_on_o, aux_en_o, aux_sink_o}, 4'b1010);
    drive(0, 0); step(3);
    chk("R5 paused", {aux_en_o, hs_on_o, ls_on_o, aux_sink_o}, 4'b0100);
    count_to_exit(cnt);
    chk("R8 halt length", cnt, 6);
    chk("R9 load handoff", {hs_on_o, ls_on_o}, 2'b01);
    step(1);
    chk("R9 load pass", {hs_on_o, ls_on_o}, {ss_hs_i, ss_ls_i});
    step(3);
  endtask

  task automatic t_retrigger;
    int cnt = 0;
    halt_preset_i = 8;
    drive(1, 0); step(3);
    drive(0, 0); step(3);
    chk("R5 unload paused", {aux_en_o, ls_on_o}, 2'b01);
    step(2);
    drive(1, 0); step(3);
    chk("R6 rearm", {aux_en_o, aux_sink_o, exit_o}, 3'b110);
    drive(0, 0); step(3);
    count_to_exit(cnt);
    chk("R6 count cleared", cnt, 9);
    step(4);
  endtask

  task automatic t_invalid_transient;
    int cnt = 0;
    halt_preset_i = 10;
    drive(1, 0); step(3);
    drive(1, 1); step(3);
    chk("R11 aux holds", {aux_en_o, ls_on_o}, 2'b11);
    drive(0, 0); step(3);
    chk("R5 pause", aux_en_o, 0);
    drive(1, 1);
    for (int k = 0; k < 4; k++) begin
      step(1);
      cnt++;
      chk("R11 paused both", {aux_en_o, exit_o}, 2'b00);
    end
    drive(0, 0);
    count_to_exit(cnt);
    chk("R11 frozen count", cnt, 15);
    step(4);
  endtask

  initial begin
    step(2);
    rst_ni = 1'b1;
    step(1);
    t_reset();
    t_steady_pass();
    t_invalid_steady();
    t_unload_invert();
    t_load_timer();
    t_retrigger();
    t_invalid_transient();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule